// File: doc/BRIEF.md
# Interrupt Entry State Generator

This block produces the architectural state an in-order core needs when it enters an interrupt handler, either for a taken trap or for a system call. A request carries the current 64-bit machine status word, the address of the current instruction, a 5-bit cause-type vector, a handler vector field and a flag that marks the request as a system call. One clock later the block presents four results: the new status word, the saved program counter, the saved status word with the cause encoded in fixed bit slots, and the handler address. Each result has its own valid flag.

Status bits are named with big-endian numbering: bit 0 is the most significant. Bit number n sits at index 63-n of the packed vector. A small control unit turns the request into a strobe struct. A datapath computes every result and registers it on that strobe. A thin top joins the two.

Top module: `irq_entry_gen`

## Requirements
- R1: The four valid flags are high in exactly the cycle after a cycle in which `reqValid` was sampled high, and are low in every other cycle.
- R2: For a trap request (`reqSysCall` low), `savedPc` equals the `curPc` of that request.
- R3: For a system call request (`reqSysCall` high), `savedPc` equals `curPc` plus 4, wrapping modulo 2^ADDR_W.
- R4: `nextPc` equals `vectorField` shifted left by VEC_SHIFT (default 4) bits with zero fill, for both kinds of request.
- R5: `savedStatus` copies `curStatus` in every bit number except 33 to 36, which are cleared, and 42 to 47, which hold the cause slots.
- R6: For a trap, the cause slots in `savedStatus` take these values, where `causeType` bit 0 is its least significant bit:
  - bit 42 = 0
  - bit 43 = causeType[0] (floating point)
  - bit 44 = causeType[4] (illegal)
  - bit 45 = causeType[1] (privileged)
  - bit 46 = 1 exactly when causeType is all zero (plain trap)
  - bit 47 = causeType[3] (address)

  causeType[2] reaches no slot.
- R7: For a system call, bits 42 to 47 of `savedStatus` are all zero whatever `causeType` holds.
- R8: `newStatus` clears bit numbers 5, 31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 61 and 62.
- R9: `newStatus` sets bit numbers 0 (64-bit mode) and 63 (little-endian) and copies every other bit from `curStatus`.
- R10: After reset, all four results read zero and all valid flags are low until the first request.
- R11: In a cycle with no request, all four results keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Interrupt entry request this cycle |
| reqSysCall | input | 1 | Request is a system call rather than a trap |
| curStatus | input | 64 | Current machine status word |
| curPc | input | ADDR_W | Address of the current instruction |
| causeType | input | 5 | Trap cause-type vector |
| vectorField | input | ADDR_W-VEC_SHIFT | Handler vector field |
| newStatus | output | 64 | Status word on handler entry |
| newStatusValid | output | 1 | newStatus is valid |
| savedPc | output | ADDR_W | Saved program counter |
| savedPcValid | output | 1 | savedPc is valid |
| savedStatus | output | 64 | Saved status word with cause slots |
| savedStatusValid | output | 1 | savedStatus is valid |
| nextPc | output | ADDR_W | Handler address |
| nextPcValid | output | 1 | nextPc is valid |

## Verification
A request can have the system-call select high while `causeType` is nonzero. In that case the system-call path must win: the cause slots read zero and the saved address is incremented. The bench drives system calls with every single-bit cause type and with an all-ones cause type, and the scoreboard checks all six slots and the saved address. The bench also issues requests back to back, so that one result is presented in the same cycle the next request is captured. The four valid flags must then stay high in consecutive cycles, and each result must match its own request.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam int STATUS_W = 64;
  localparam int CAUSE_W  = 5;

  // Big-endian bit numbers of the cause slots in the saved status word
  localparam int SLOT_ZERO_BIT  = 42;
  localparam int SLOT_FP_BIT    = 43;
  localparam int SLOT_ILLEG_BIT = 44;
  localparam int SLOT_PRIV_BIT  = 45;
  localparam int SLOT_PLAIN_BIT = 46;
  localparam int SLOT_ADDR_BIT  = 47;
  localparam int WIPE_LO_BIT    = 33;
  localparam int WIPE_HI_BIT    = 36;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic sysCall;
  } entryStrobe_t;

  function automatic int beIdx(input int n);
    return STATUS_W - 1 - n;
  endfunction

  function automatic logic [STATUS_W-1:0] beMask(input int n);
    logic [STATUS_W-1:0] m;
    m = '0;
    m[STATUS_W-1-n] = 1'b1;
    return m;
  endfunction

  function automatic logic [STATUS_W-1:0] beRange(input int lo, input int hi);
    logic [STATUS_W-1:0] m;
    m = '0;
    for (int n = lo; n <= hi; n++) m[STATUS_W-1-n] = 1'b1;
    return m;
  endfunction

  // Mode bits dropped on handler entry
  localparam logic [STATUS_W-1:0] ENTRY_CLEAR_MASK =
      beMask(5)  | beMask(31) | beMask(38) | beMask(40) |
      beMask(48) | beMask(49) | beMask(50) | beMask(52) |
      beMask(53) | beMask(54) | beMask(55) | beMask(58) |
      beMask(59) | beMask(61) | beMask(62);

  // Mode bits forced on handler entry: 64-bit mode, little-endian
  localparam logic [STATUS_W-1:0] ENTRY_SET_MASK = beMask(0) | beMask(63);

  // Saved-status bits replaced by zero or by cause slots
  localparam logic [STATUS_W-1:0] SAVE_WIPE_MASK =
      beRange(WIPE_LO_BIT, WIPE_HI_BIT) | beRange(SLOT_ZERO_BIT, SLOT_ADDR_BIT);

endpackage

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         reqSysCall,
  output entryStrobe_t strb,
  output logic         outValid
);

  always_comb begin
    strb.load    = reqValid;
    strb.sysCall = reqValid & reqSysCall;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= reqValid;
  end

  // R1: result flag follows each request by one cycle
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> outValid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !outValid);

endmodule

// File: rtl/irq_entry_datapath.sv
module irq_entry_datapath
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int VEC_SHIFT  = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  entryStrobe_t            strb,
  input  logic [STATUS_W-1:0]     statusIn,
  input  logic [ADDR_W-1:0]       pcIn,
  input  logic [CAUSE_W-1:0]      causeIn,
  input  logic [ADDR_W-VEC_SHIFT-1:0] vecIn,
  output logic [STATUS_W-1:0]     newStatusQ,
  output logic [ADDR_W-1:0]       savedPcQ,
  output logic [STATUS_W-1:0]     savedStatusQ,
  output logic [ADDR_W-1:0]       nextPcQ
);

  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(INSN_BYTES);

  logic [STATUS_W-1:0] newStatusD;
  logic [STATUS_W-1:0] savedStatusD;
  logic [ADDR_W-1:0]   savedPcD;
  logic [ADDR_W-1:0]   nextPcD;
  logic                trapCause;

  always_comb begin
    trapCause  = ~strb.sysCall;
    newStatusD = (statusIn & ~ENTRY_CLEAR_MASK) | ENTRY_SET_MASK;

    savedStatusD = statusIn & ~SAVE_WIPE_MASK;
    savedStatusD[beIdx(SLOT_ZERO_BIT)]  = 1'b0;
    savedStatusD[beIdx(SLOT_FP_BIT)]    = trapCause & causeIn[0];
    savedStatusD[beIdx(SLOT_ILLEG_BIT)] = trapCause & causeIn[4];
    savedStatusD[beIdx(SLOT_PRIV_BIT)]  = trapCause & causeIn[1];
    savedStatusD[beIdx(SLOT_PLAIN_BIT)] = trapCause & (causeIn == '0);
    savedStatusD[beIdx(SLOT_ADDR_BIT)]  = trapCause & causeIn[3];

    savedPcD = strb.sysCall ? (pcIn + PC_STEP) : pcIn;
    nextPcD  = {vecIn, {VEC_SHIFT{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      newStatusQ   <= '0;
      savedPcQ     <= '0;
      savedStatusQ <= '0;
      nextPcQ      <= '0;
    end else if (strb.load) begin
      newStatusQ   <= newStatusD;
      savedPcQ     <= savedPcD;
      savedStatusQ <= savedStatusD;
      nextPcQ      <= nextPcD;
    end
  end

  p_trap_pc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && !strb.sysCall) |=> savedPcQ == $past(pcIn));

  p_sc_pc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && strb.sysCall) |=> savedPcQ == $past(pcIn) + PC_STEP);

  p_vector_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> (nextPcQ >> VEC_SHIFT) == ADDR_W'($past(vecIn)));

  p_plain_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && !strb.sysCall) |=>
      savedStatusQ[beIdx(SLOT_PLAIN_BIT)] == ($past(causeIn) == '0));

  p_sc_slots_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.load && strb.sysCall) |=>
      $countones(savedStatusQ[beIdx(SLOT_ZERO_BIT):beIdx(SLOT_ADDR_BIT)]) == 0);

  p_mode_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.load |=> newStatusQ[beIdx(0)] && newStatusQ[beIdx(63)]);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.load |=> $stable(newStatusQ) && $stable(savedPcQ) &&
                   $stable(savedStatusQ) && $stable(nextPcQ));

endmodule

// File: rtl/irq_entry_gen.sv
module irq_entry_gen
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int VEC_SHIFT = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reqValid,
  input  logic                        reqSysCall,
  input  logic [63:0]                 curStatus,
  input  logic [ADDR_W-1:0]           curPc,
  input  logic [4:0]                  causeType,
  input  logic [ADDR_W-VEC_SHIFT-1:0] vectorField,
  output logic [63:0]                 newStatus,
  output logic                        newStatusValid,
  output logic [ADDR_W-1:0]           savedPc,
  output logic                        savedPcValid,
  output logic [63:0]                 savedStatus,
  output logic                        savedStatusValid,
  output logic [ADDR_W-1:0]           nextPc,
  output logic                        nextPcValid
);

  entryStrobe_t strb;
  logic         outValid;

  irq_entry_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqSysCall (reqSysCall),
    .strb       (strb),
    .outValid   (outValid)
  );

  irq_entry_datapath #(
    .ADDR_W    (ADDR_W),
    .VEC_SHIFT (VEC_SHIFT)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .statusIn     (curStatus),
    .pcIn         (curPc),
    .causeIn      (causeType),
    .vecIn        (vectorField),
    .newStatusQ   (newStatus),
    .savedPcQ     (savedPc),
    .savedStatusQ (savedStatus),
    .nextPcQ      (nextPc)
  );

  assign newStatusValid   = outValid;
  assign savedPcValid     = outValid;
  assign savedStatusValid = outValid;
  assign nextPcValid      = outValid;

endmodule

// File: tb/irq_entry_gen_test.sv
module irq_entry_gen_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqSysCall = 1'b0;
  logic [63:0] curStatus = '0;
  logic [63:0] curPc = '0;
  logic [4:0]  causeType = '0;
  logic [59:0] vectorField = '0;
  logic [63:0] newStatus, savedPc, savedStatus, nextPc;
  logic        newStatusValid, savedPcValid, savedStatusValid, nextPcValid;

  irq_entry_gen uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqSysCall(reqSysCall),
    .curStatus(curStatus), .curPc(curPc), .causeType(causeType),
    .vectorField(vectorField),
    .newStatus(newStatus), .newStatusValid(newStatusValid),
    .savedPc(savedPc), .savedPcValid(savedPcValid),
    .savedStatus(savedStatus), .savedStatusValid(savedStatusValid),
    .nextPc(nextPc), .nextPcValid(nextPcValid)
  );

  always #4ns clk = ~clk;

  typedef struct {
    int          due;
    logic        sc;
    logic [63:0] st;
    logic [63:0] pc;
    logic [63:0] s1;
    logic [63:0] np;
  } item_t;

  item_t queueExp[$];
  item_t lastExp;
  int    cyc = 0;
  int    total = 0;
  int    fails = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [63:0] putBit(logic [63:0] v, int n, logic b);
    v[63 - n] = b;
    return v;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Reference model built from the requirement text
  function automatic item_t model(logic sc, logic [63:0] st, logic [63:0] pc,
                                  logic [4:0] ty, logic [59:0] vec);
    item_t it;
    int clr[15] = '{5, 31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 61, 62};
    it.sc = sc;
    it.st = st;
    foreach (clr[k]) it.st = putBit(it.st, clr[k], 1'b0);           // R8
    it.st = putBit(it.st, 0, 1'b1);                                  // R9
    it.st = putBit(it.st, 63, 1'b1);
    it.pc = sc ? pc + 64'd4 : pc;                                    // R2 R3
    it.np = {vec, 4'b0};                                             // R4
    it.s1 = st;                                                      // R5
    for (int n = 33; n <= 36; n++) it.s1 = putBit(it.s1, n, 1'b0);
    it.s1 = putBit(it.s1, 42, 1'b0);
    it.s1 = putBit(it.s1, 43, !sc && ty[0]);                         // R6 R7
    it.s1 = putBit(it.s1, 44, !sc && ty[4]);
    it.s1 = putBit(it.s1, 45, !sc && ty[1]);
    it.s1 = putBit(it.s1, 46, !sc && (ty == 5'd0));
    it.s1 = putBit(it.s1, 47, !sc && ty[3]);
    return it;
  endfunction

  task automatic drive(logic sc, logic [63:0] st, logic [63:0] pc,
                       logic [4:0] ty, logic [59:0] vec);
    item_t it;
    @(negedge clk);
    reqValid = 1'b1; reqSysCall = sc; curStatus = st; curPc = pc;
    causeType = ty; vectorField = vec;
    it = model(sc, st, pc, ty, vec);
    it.due = cyc + 1;
    queueExp.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      reqSysCall = $urandom_range(0, 1);
      curStatus = {$urandom, $urandom};
      causeType = 5'($urandom);
    end
  endtask

  // Monitor: compares outputs against scoreboard entries
  initial begin
    lastExp = '{due: 0, sc: 0, st: '0, pc: '0, s1: '0, np: '0};
    forever begin
      @(negedge clk);
      #2ns;
      if (rst_n) begin
        logic expV;
        expV = (queueExp.size() > 0) && (queueExp[0].due == cyc);
        check("R1 newStatusValid",   64'(newStatusValid),   64'(expV));
        check("R1 savedPcValid",     64'(savedPcValid),     64'(expV));
        check("R1 savedStatusValid", 64'(savedStatusValid), 64'(expV));
        check("R1 nextPcValid",      64'(nextPcValid),      64'(expV));
        if (expV) begin
          item_t it;
          it = queueExp.pop_front();
          check("R8,R9 newStatus", newStatus, it.st);
          check(it.sc ? "R3 savedPc" : "R2 savedPc", savedPc, it.pc);
          check(it.sc ? "R5,R7 savedStatus" : "R5,R6 savedStatus", savedStatus, it.s1);
          check("R4 nextPc", nextPc, it.np);
          lastExp = it;
        end else begin
          string tg;
          tg = (lastExp.due == 0) ? "R10" : "R11";
          check({tg, " newStatus"},   newStatus,   lastExp.st);
          check({tg, " savedPc"},     savedPc,     lastExp.pc);
          check({tg, " savedStatus"}, savedStatus, lastExp.s1);
          check({tg, " nextPc"},      nextPc,      lastExp.np);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);                                         // R10 reset state
    // Plain trap and each single cause bit (R6)
    drive(1'b0, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_1000, 5'b00000, 60'h70);
    idle(2);                                         // R11 hold
    for (int b = 0; b < 5; b++) begin
      drive(1'b0, {$urandom, $urandom}, {$urandom, $urandom}, 5'(1 << b), 60'($urandom));
      idle(1);
    end
    // Status all ones / all zeros (R5 R8 R9)
    drive(1'b0, '1, 64'hFFFF_FFFF_FFFF_FFF0, 5'b11111, '1);
    drive(1'b0, '0, 64'h0, 5'b00000, '0);
    idle(1);
    // System call with nonzero cause: select wins (R7), wrap (R3)
    drive(1'b1, '1, 64'hFFFF_FFFF_FFFF_FFFC, 5'b11111, 60'h0C);
    for (int b = 0; b < 5; b++) drive(1'b1, {$urandom, $urandom},
                                      {$urandom, $urandom}, 5'(1 << b), 60'($urandom));
    drive(1'b1, 64'h8000_0000_0000_0001, 64'h0, 5'b00000, 60'h1);
    idle(2);
    // Random mix, back to back and spaced
    for (int i = 0; i < 40; i++) begin
      drive(1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
            5'($urandom), {28'($urandom), $urandom});
      if (i % 3 == 0) idle($urandom_range(1, 3));
    end
    idle(4);
    check("R1 all results seen", 64'(queueExp.size()), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule